// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block brings an LCD panel's supplies up and down in a fixed, frame-counted order. When a power request arrives, it first enables the panel's logic supply. After a programmed number of frames, it opens the gate that lets the display data and timing signals reach the panel. After a second programmed number of frames, it enables the high-voltage supply. When the request is withdrawn, the same steps run in reverse, each with its own programmed frame wait. Frames are counted on a one-cycle frame tick that the display timing generator supplies. The timing generator itself sits outside this block.

Four 4-bit wait fields live in one 16-bit register. Software writes that register through a simple write port and can read it back at any time. Each field holds the wanted number of frames minus one. A wait counter takes its field value only on entry to a wait step. A write therefore never disturbs a count already running; it applies from the next wait step onward. If the request is withdrawn part way through power-on, the sequencer jumps to the matching point of the power-off path. A power-off sequence, once started, always runs to the end.

Top module: `lcd_pwr_seq`

## Requirements
- R1: The period register resets to 0xF60F and a write replaces all 16 bits, which read back on `cfg_rdata` the cycle after the write. Field layout: bits 15:12 = power-on wait before the display gate (A), 11:8 = power-on wait before high voltage (B), 7:4 = power-off wait after high voltage drops (E), 3:0 = power-off wait before the logic supply drops (F).
- R2: During and after reset, with no request, `logic_en`, `disp_gate` and `hv_en` are 0 and `status` is 0.
- R3: From idle, `logic_en` rises in the cycle after `pwr_req` is first sampled high.
- R4: `disp_gate` rises in the cycle after the (A+1)-th frame tick counted from the entry into the first power-on wait.
- R5: `hv_en` rises in the cycle after the (B+1)-th frame tick counted from the rise of `disp_gate`.
- R6: From fully on, `hv_en` falls the cycle after `pwr_req` is sampled low. `disp_gate` falls after E+1 further ticks, and `logic_en` falls after F+1 more ticks.
- R7: At all times `hv_en` implies `disp_gate`, and `disp_gate` implies `logic_en`.
- R8: Withdrawing the request during the first power-on wait leaves `disp_gate` and `hv_en` low. `logic_en` then stays high for F+1 frame ticks and falls.
- R9: Withdrawing the request during the second power-on wait leaves `hv_en` low. `disp_gate` falls after E+1 ticks, and `logic_en` falls after F+1 more ticks.
- R10: A register write made during a wait does not change the wait in progress. The new field values govern every wait entered later.
- R11: `status` is 0 when fully off, 2 when fully on (all three outputs high), and 1 in every wait step.
- R12: A power-off sequence runs to completion even if `pwr_req` returns high. If the request is then still high, a new power-on starts in the cycle after idle is reached.
- R13: Cycles without a frame tick never advance a wait, and no output changes while `pwr_req` is steady and no tick arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle pulse per display frame |
| pwr_req | input | 1 | Panel power request, level sensitive |
| cfg_we | input | 1 | Write strobe for the period register |
| cfg_wdata | input | 16 | Write data for the period register |
| cfg_rdata | output | 16 | Current period register contents |
| logic_en | output | 1 | Panel logic-supply enable |
| disp_gate | output | 1 | Enable for the display data and timing outputs |
| hv_en | output | 1 | Panel high-voltage supply enable |
| status | output | 2 | 0 idle off, 1 sequencing, 2 fully on |

## Verification
The hardest case to reach is a register write that lands while a wait is already counting. The write must leave the current count alone and still apply to the following step. The stimulus starts a power-on with a short first wait. Between frame ticks it writes a long first wait together with a different second wait. It then checks that the display gate opens on the old count and that the high-voltage enable follows on the new count. The aborts from each power-on wait are timed the same way, a tick or two into the count, and so is a request that returns high during the power-off path.

// File: rtl/lcd_pwr_pkg.sv
package lcd_pwr_pkg;

    localparam int FIELD_W = 4;
    localparam int NUM_FIELDS = 4;
    localparam int REG_W = FIELD_W * NUM_FIELDS;
    localparam logic [REG_W-1:0] CFG_RST = 16'hF60F;

    // Sequencer states: one idle, one steady-on, four frame-counted waits.
    typedef enum logic [2:0] {
        PS_OFF     = 3'd0,
        PS_WAIT_A  = 3'd1,   // logic supply on, gate closed
        PS_WAIT_B  = 3'd2,   // gate open, high voltage off
        PS_FULL_ON = 3'd3,
        PS_WAIT_E  = 3'd4,   // high voltage dropped, gate still open
        PS_WAIT_F  = 3'd5    // gate closed, logic supply still on
    } pwr_state_e;

    typedef enum logic [1:0] {
        STS_IDLE = 2'd0,
        STS_SEQ  = 2'd1,
        STS_ON   = 2'd2
    } pwr_status_e;

    // Field order follows the register bit layout, MSB first.
    typedef struct packed {
        logic [FIELD_W-1:0] on_a;
        logic [FIELD_W-1:0] on_b;
        logic [FIELD_W-1:0] off_e;
        logic [FIELD_W-1:0] off_f;
    } period_cfg_t;

    typedef struct packed {
        logic logic_en;
        logic disp_gate;
        logic hv_en;
    } rail_ctl_t;

    function automatic rail_ctl_t rails_for(input pwr_state_e s);
        rail_ctl_t r;
        r.logic_en  = (s != PS_OFF);
        r.disp_gate = (s == PS_WAIT_B) || (s == PS_FULL_ON) || (s == PS_WAIT_E);
        r.hv_en     = (s == PS_FULL_ON);
        return r;
    endfunction

    function automatic pwr_status_e status_for(input pwr_state_e s);
        pwr_status_e v;
        case (s)
            PS_OFF:     v = STS_IDLE;
            PS_FULL_ON: v = STS_ON;
            default:    v = STS_SEQ;
        endcase
        return v;
    endfunction

    function automatic logic is_wait(input pwr_state_e s);
        return (s == PS_WAIT_A) || (s == PS_WAIT_B) ||
               (s == PS_WAIT_E) || (s == PS_WAIT_F);
    endfunction

    // Period field governing the wait in state s (zero for non-wait states).
    function automatic logic [FIELD_W-1:0] field_for(input pwr_state_e s,
                                                     input period_cfg_t c);
        logic [FIELD_W-1:0] v;
        case (s)
            PS_WAIT_A: v = c.on_a;
            PS_WAIT_B: v = c.on_b;
            PS_WAIT_E: v = c.off_e;
            PS_WAIT_F: v = c.off_f;
            default:   v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/lcd_pwr_cfg.sv
module lcd_pwr_cfg
    import lcd_pwr_pkg::*;
#(
    parameter int               W       = REG_W,
    parameter logic [W-1:0]     RST_VAL = CFG_RST
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= RST_VAL;
        else if (we)
            q <= wdata;
    end

    // R1: a write is visible in full on the following cycle
    a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> (q == $past(wdata)));

    // R1: without a write the contents never move
    a_r1_hold_no_write: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

endmodule

// File: rtl/lcd_pwr_frmcnt.sv
module lcd_pwr_frmcnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         expired
);

    logic [W-1:0] cnt;
    logic         at_zero;

    assign at_zero = (cnt == '0);
    assign expired = tick && at_zero;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (tick && !at_zero)
            cnt <= cnt - 1'b1;
    end

    // R13: the count is frozen in cycles without a frame tick
    a_r13_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!load && !tick) |=> $stable(cnt));

    // R10: a load always lands the selected field, whatever tick does
    a_r10_load_lands: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/lcd_pwr_fsm.sv
module lcd_pwr_fsm
    import lcd_pwr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_req,
    input  logic               expired,
    input  period_cfg_t        cfg,
    output logic               cnt_load,
    output logic [FIELD_W-1:0] cnt_val,
    output pwr_state_e         state
);

    pwr_state_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            PS_OFF:     if (pwr_req) nxt = PS_WAIT_A;
            PS_WAIT_A:  if (!pwr_req) nxt = PS_WAIT_F;
                        else if (expired) nxt = PS_WAIT_B;
            PS_WAIT_B:  if (!pwr_req) nxt = PS_WAIT_E;
                        else if (expired) nxt = PS_FULL_ON;
            PS_FULL_ON: if (!pwr_req) nxt = PS_WAIT_E;
            PS_WAIT_E:  if (expired) nxt = PS_WAIT_F;
            PS_WAIT_F:  if (expired) nxt = PS_OFF;
            default:    nxt = PS_OFF;
        endcase
    end

    // Reload the frame counter only when a wait step is entered.
    assign cnt_load = (nxt != state) && is_wait(nxt);
    assign cnt_val  = field_for(nxt, cfg);

    always_ff @(posedge clk) begin
        if (rst)
            state <= PS_OFF;
        else
            state <= nxt;
    end

    // R3: idle is left only towards the first power-on wait
    a_r3_exit_idle: assert property (@(posedge clk) disable iff (rst)
        (state == PS_OFF && pwr_req) |=> (state == PS_WAIT_A));

    // R12: the power-off path never turns back towards power-on
    a_r12_off_path_forward: assert property (@(posedge clk) disable iff (rst)
        (state == PS_WAIT_E) |=> (state == PS_WAIT_E || state == PS_WAIT_F));

    // R6: idle is reached only from the last off wait on an expired count
    a_r6_idle_entry: assert property (@(posedge clk) disable iff (rst)
        (state == PS_OFF && $past(state) != PS_OFF) |->
            ($past(state) == PS_WAIT_F && $past(expired)));

    // R8: an abort in the first wait skips the display gate entirely
    a_r8_abort_a: assert property (@(posedge clk) disable iff (rst)
        (state == PS_WAIT_A && !pwr_req) |=> (state == PS_WAIT_F));

    // R9: an abort in the second wait never raises the high voltage
    a_r9_abort_b: assert property (@(posedge clk) disable iff (rst)
        (state == PS_WAIT_B && !pwr_req) |=> (state == PS_WAIT_E));

endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
    import lcd_pwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_tick,
    input  logic             pwr_req,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output logic             logic_en,
    output logic             disp_gate,
    output logic             hv_en,
    output logic [1:0]       status
);

    period_cfg_t        cfg;
    pwr_state_e         state;
    logic               cnt_load;
    logic [FIELD_W-1:0] cnt_val;
    logic               expired;
    rail_ctl_t          rails;

    lcd_pwr_cfg #(
        .W       (REG_W),
        .RST_VAL (CFG_RST)
    ) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .q     (cfg_rdata)
    );

    assign cfg = period_cfg_t'(cfg_rdata);

    lcd_pwr_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .pwr_req  (pwr_req),
        .expired  (expired),
        .cfg      (cfg),
        .cnt_load (cnt_load),
        .cnt_val  (cnt_val),
        .state    (state)
    );

    lcd_pwr_frmcnt #(
        .W (FIELD_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .tick     (frame_tick),
        .expired  (expired)
    );

    assign rails     = rails_for(state);
    assign logic_en  = rails.logic_en;
    assign disp_gate = rails.disp_gate;
    assign hv_en     = rails.hv_en;
    assign status    = status_for(state);

    // R7: rail ordering holds in every cycle
    a_r7_rail_order: assert property (@(posedge clk) disable iff (rst)
        (hv_en |-> disp_gate) and (disp_gate |-> logic_en));

    // R11: fully on exactly when all three outputs are high
    a_r11_status_on: assert property (@(posedge clk) disable iff (rst)
        (status == 2'd2) == (hv_en && disp_gate && logic_en));

    // R2: reset clears every output
    a_r2_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!logic_en && !disp_gate && !hv_en && status == 2'd0));

    // R5: high voltage rises only after the gate has been open
    a_r5_hv_after_gate: assert property (@(posedge clk) disable iff (rst)
        $rose(hv_en) |-> $past(disp_gate));

endmodule

// File: tb/tb_lcd_pwr_seq.sv
module tb_lcd_pwr_seq;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_tick = 1'b0;
    logic        pwr_req = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        logic_en, disp_gate, hv_en;
    logic [1:0]  status;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    typedef struct {
        int    at;
        logic  le;
        logic  dg;
        logic  hv;
        logic [1:0] st;
        string tag;
    } exp_t;

    exp_t sb[$];

    lcd_pwr_seq dut (
        .clk(clk), .rst(rst), .frame_tick(frame_tick), .pwr_req(pwr_req),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .logic_en(logic_en), .disp_gate(disp_gate), .hv_en(hv_en),
        .status(status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops expectations due this cycle and compares at the falling edge.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (logic_en !== e.le || disp_gate !== e.dg || hv_en !== e.hv || status !== e.st) begin
                failures++;
                $display("FAIL %s cyc=%0d actual le/dg/hv/st=%b%b%b/%0d expected %b%b%b/%0d",
                         e.tag, cyc, logic_en, disp_gate, hv_en, status,
                         e.le, e.dg, e.hv, e.st);
            end
        end
        if (!rst) begin
            checks++;
            if ((hv_en && !disp_gate) || (disp_gate && !logic_en)) begin
                failures++;
                $display("FAIL R7 cyc=%0d actual le/dg/hv=%b%b%b expected ordered rails",
                         cyc, logic_en, disp_gate, hv_en);
            end
        end
    end

    // Driver: queue what the outputs must show after the edge just taken.
    task automatic expect_out(input logic le, input logic dg, input logic hv,
                              input logic [1:0] st, input string tag);
        exp_t e;
        e.at = cyc; e.le = le; e.dg = dg; e.hv = hv; e.st = st; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic drive_cycle(input logic tk, input logic req);
        frame_tick = tk;
        pwr_req = req;
        @(posedge clk);
        #1;
        frame_tick = 1'b0;
    endtask

    // n ticks separated by idle cycles; outputs hold until the n-th tick,
    // whose result the caller checks.
    task automatic hold_frames(input int n, input logic req, input logic le,
                               input logic dg, input logic hv,
                               input logic [1:0] st, input string tag);
        for (int i = 0; i < n; i++) begin
            drive_cycle(1'b1, req);
            if (i < n - 1) begin
                expect_out(le, dg, hv, st, tag);
                drive_cycle(1'b0, req);
                expect_out(le, dg, hv, st, tag);
            end
        end
    endtask

    task automatic cfg_write(input logic [15:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    task automatic check_reg(input logic [15:0] v, input string tag);
        @(negedge clk);
        checks++;
        if (cfg_rdata !== v) begin
            failures++;
            $display("FAIL %s actual cfg=%h expected %h", tag, cfg_rdata, v);
        end
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        drive_cycle(1'b0, 1'b0);
        expect_out(0, 0, 0, 2'd0, "R2");
        check_reg(16'hF60F, "R1 reset value");
        drive_cycle(1'b1, 1'b0);
        expect_out(0, 0, 0, 2'd0, "R2 tick while idle");

        // Full power-on and power-off: A=2 B=3 E=1 F=0
        cfg_write(16'h2310);
        check_reg(16'h2310, "R1 write");
        drive_cycle(1'b0, 1'b1);
        expect_out(1, 0, 0, 2'd1, "R3/R11");
        hold_frames(3, 1'b1, 1, 0, 0, 2'd1, "R4");
        expect_out(1, 1, 0, 2'd1, "R4");
        hold_frames(4, 1'b1, 1, 1, 0, 2'd1, "R5");
        expect_out(1, 1, 1, 2'd2, "R5/R11");
        for (int i = 0; i < 4; i++) begin
            drive_cycle(1'b0, 1'b1);
            expect_out(1, 1, 1, 2'd2, "R13 steady on");
        end
        drive_cycle(1'b0, 1'b0);
        expect_out(1, 1, 0, 2'd1, "R6 hv drop");
        for (int i = 0; i < 3; i++) begin
            drive_cycle(1'b0, 1'b0);
            expect_out(1, 1, 0, 2'd1, "R13 no tick");
        end
        hold_frames(2, 1'b0, 1, 1, 0, 2'd1, "R6");
        expect_out(1, 0, 0, 2'd1, "R6 gate drop");
        hold_frames(1, 1'b0, 1, 0, 0, 2'd1, "R6");
        expect_out(0, 0, 0, 2'd0, "R6 logic drop");

        // Abort in first wait: A=5 E=0 F=1
        cfg_write(16'h5001);
        drive_cycle(1'b0, 1'b1);
        expect_out(1, 0, 0, 2'd1, "R8");
        drive_cycle(1'b1, 1'b1);
        expect_out(1, 0, 0, 2'd1, "R8");
        drive_cycle(1'b1, 1'b1);
        expect_out(1, 0, 0, 2'd1, "R8");
        drive_cycle(1'b0, 1'b0);
        expect_out(1, 0, 0, 2'd1, "R8 abort");
        hold_frames(2, 1'b0, 1, 0, 0, 2'd1, "R8");
        expect_out(0, 0, 0, 2'd0, "R8 logic drop");

        // Abort in second wait: A=0 B=4 E=1 F=0
        cfg_write(16'h0410);
        drive_cycle(1'b0, 1'b1);
        expect_out(1, 0, 0, 2'd1, "R9");
        hold_frames(1, 1'b1, 1, 0, 0, 2'd1, "R9");
        expect_out(1, 1, 0, 2'd1, "R9 gate");
        drive_cycle(1'b1, 1'b1);
        expect_out(1, 1, 0, 2'd1, "R9");
        drive_cycle(1'b0, 1'b0);
        expect_out(1, 1, 0, 2'd1, "R9 abort");
        hold_frames(2, 1'b0, 1, 1, 0, 2'd1, "R9");
        expect_out(1, 0, 0, 2'd1, "R9 gate drop");
        hold_frames(1, 1'b0, 1, 0, 0, 2'd1, "R9");
        expect_out(0, 0, 0, 2'd0, "R9 logic drop");

        // Write during a count: A=2 running, rewrite to A=15 B=3
        cfg_write(16'h2100);
        drive_cycle(1'b0, 1'b1);
        expect_out(1, 0, 0, 2'd1, "R10");
        drive_cycle(1'b1, 1'b1);
        expect_out(1, 0, 0, 2'd1, "R10");
        pwr_req = 1'b1;
        cfg_write(16'hF300);
        expect_out(1, 0, 0, 2'd1, "R10 write mid count");
        hold_frames(2, 1'b1, 1, 0, 0, 2'd1, "R10");
        expect_out(1, 1, 0, 2'd1, "R10 old A used");
        hold_frames(4, 1'b1, 1, 1, 0, 2'd1, "R10");
        expect_out(1, 1, 1, 2'd2, "R10 new B used");
        drive_cycle(1'b0, 1'b0);
        expect_out(1, 1, 0, 2'd1, "R10");
        hold_frames(1, 1'b0, 1, 1, 0, 2'd1, "R10");
        expect_out(1, 0, 0, 2'd1, "R10");
        hold_frames(1, 1'b0, 1, 0, 0, 2'd1, "R10");
        expect_out(0, 0, 0, 2'd0, "R10");

        // Request returns during power-off: A=0 B=0 E=1 F=1
        cfg_write(16'h0011);
        drive_cycle(1'b0, 1'b1);
        expect_out(1, 0, 0, 2'd1, "R12");
        drive_cycle(1'b1, 1'b1);
        expect_out(1, 1, 0, 2'd1, "R12");
        drive_cycle(1'b1, 1'b1);
        expect_out(1, 1, 1, 2'd2, "R12");
        drive_cycle(1'b0, 1'b0);
        expect_out(1, 1, 0, 2'd1, "R12");
        hold_frames(2, 1'b1, 1, 1, 0, 2'd1, "R12");
        expect_out(1, 0, 0, 2'd1, "R12 off continues");
        hold_frames(2, 1'b1, 1, 0, 0, 2'd1, "R12");
        expect_out(0, 0, 0, 2'd0, "R12 idle reached");
        drive_cycle(1'b0, 1'b1);
        expect_out(1, 0, 0, 2'd1, "R12 restart");
        drive_cycle(1'b0, 1'b0);
        expect_out(1, 0, 0, 2'd1, "R8");
        hold_frames(2, 1'b0, 1, 0, 0, 2'd1, "R8");
        expect_out(0, 0, 0, 2'd0, "R8");

        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule